// File: doc/BRIEF.md
# Phased Reset Sequencer

This block walks a chip through its reset in four ordered phases and then an idle phase. Each phase waits for two things: a "done" handshake from the engine that works in that phase, and a minimum number of oscillator cycles. The phases run in this order: power and oscillator stabilisation, a long functional hold, flash initialisation, then trim and self-test configuration. While any phase other than idle is active, the system is held in reset. Once idle is reached, the system is released.

Reset requests fall into three severity classes. Power-on and enabled destructive requests are the severest. Any of them throws the sequencer back to phase 0 from anywhere. Unmasked external requests and long functional requests restart the sequence at phase 1. Short functional requests, accepted only in idle, re-enter the sequence at phase 3.

A saturating escalation counter counts destructive events. When the count reaches a programmed threshold, the sequencer is locked in phase 0. Only a power-on event clears the counter.

Top module: `rst_phase_seq`

## Requirements
- R1: While `rst_n` is low, `phase_oh` is 5'b00001 (bit 0 = phase 0, bit 1 = phase 1, bit 2 = phase 2, bit 3 = phase 3, bit 4 = idle), `sys_rst` is 1 and `esc_lock` is 0 (counter cleared).
- R2: A clock edge that sees `por_req` high, or any `dst_req[i]` with `dst_en[i]` high, moves the sequencer to phase 0 from any phase and restarts its timer. A request whose enable bit is 0 has no effect.
- R3: Phase 0 advances to phase 1 only when all of the following hold:
  - no hard request is active;
  - `pwr_ok` is 1;
  - `esc_lock` is 0;
  - phase 0 has lasted `MIN_P0` (8) cycles since entry or since the last hard request was seen.
- R4: An external request with `ext_mask` low, or an enabled functional request whose `fun_short` bit is 0, moves phases 2, 3 and idle to phase 1. When `ext_mask` is 1, the external request is ignored.
- R5: Phase 1 advances to phase 2 `MIN_P1` (750) cycles after the last edge that saw a long request. It stays in phase 1 while a long request is held.
- R6: Phase 2 advances to phase 3 only when `flash_done` is 1 and phase 2 has lasted at least `MIN_P2` (8) cycles.
- R7: An enabled functional request with `fun_short` = 1 moves idle to phase 3. In phases 0, 1 and 2, such a request causes no jump.
- R8: Phase 3 enters idle only when `trim_done` is 1 and `MIN_P3` (160) cycles have passed since entry or since the last short request. Idle is entered only from phase 3.
- R9: While `err_pin` is 1, phase 3 does not exit unless `selftest_pend` or `err_ovr` is 1.
- R10: While `por_pin` is 1, phase 3 does not exit unless `selftest_pend` is 1. `err_ovr` does not lift this block.
- R11: Each edge on which a new enabled destructive request rises adds one to an `EW`-bit saturating counter. `por_req` clears the counter. `esc_lock` is 1 when `esc_thresh` is non-zero and the count is at or above it, and phase 0 is then held. A threshold of 0 never locks.
- R12: When requests coincide, hard requests win over long ones, and long ones win over short ones.
- R13: `phase_oh` is registered and has exactly one bit set. `sys_rst` is 1 in every phase except idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous low-active reset of the sequencer flops |
| por_req | input | 1 | Power-on request level |
| dst_req | input | ND | Destructive request levels, one per source |
| dst_en | input | ND | Per-source destructive enables |
| ext_req | input | 1 | External reset request level |
| ext_mask | input | 1 | 1 masks the external request |
| fun_req | input | NF | Functional request levels |
| fun_en | input | NF | Per-source functional enables |
| fun_short | input | NF | Per-source class: 1 short, 0 long |
| pwr_ok | input | 1 | Power and oscillator stable handshake |
| flash_done | input | 1 | Flash initialisation complete |
| trim_done | input | 1 | Trim and self-test configuration complete |
| err_pin | input | 1 | Error pin level, 1 = asserted |
| por_pin | input | 1 | Power-on-reset pin level, 1 = asserted |
| selftest_pend | input | 1 | A self-test runs at the end of this sequence |
| err_ovr | input | 1 | Lets phase 3 exit despite the error pin |
| esc_thresh | input | EW | Escalation threshold, 0 disables |
| phase_oh | output | 5 | One-hot phase, bit 4 = idle |
| sys_rst | output | 1 | System held in reset |
| esc_lock | output | 1 | Escalation lock active |

## Verification
The assertions check the following on every clock:
- one-hot phase encoding and its agreement with `sys_rst`;
- the immediate jumps to phase 0, phase 1 and phase 3 with their priority;
- the handshake and error/power-pin gates that must keep a phase from advancing;
- the lock hold and the zero-threshold case.

The exact cycle on which each phase exits cannot be shown by a short property, because the windows are up to 750 cycles long. It is covered by the bench's reference model, which is compared every clock. The same applies to the timer restarts caused by held or repeated requests and to saturation and clearing of the escalation count.

// File: rtl/rst_phase_pkg.sv
`timescale 1ns/1ps
package rst_phase_pkg;

   localparam int unsigned N_PHASE = 5;

   typedef enum logic [2:0] {
      PH0     = 3'd0,
      PH1     = 3'd1,
      PH2     = 3'd2,
      PH3     = 3'd3,
      PH_IDLE = 3'd4
   } phase_e;

   function automatic logic [N_PHASE-1:0] phase_to_oh(input phase_e p);
      logic [N_PHASE-1:0] r;
      r    = '0;
      r[p] = 1'b1;
      return r;
   endfunction

endpackage

// File: rtl/rst_evt_class.sv
`timescale 1ns/1ps
// Sorts raw request levels into severity classes and finds new destructive events.
module rst_evt_class #(
   parameter int unsigned ND = 2,
   parameter int unsigned NF = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          por_req,
   input  logic [ND-1:0] dst_req,
   input  logic [ND-1:0] dst_en,
   input  logic          ext_req,
   input  logic          ext_mask,
   input  logic [NF-1:0] fun_req,
   input  logic [NF-1:0] fun_en,
   input  logic [NF-1:0] fun_short,
   output logic          hard_act,
   output logic          dst_new,
   output logic          long_act,
   output logic          short_act
);

   logic [ND-1:0] dst_live;
   logic [ND-1:0] dst_prev_q;
   logic [ND-1:0] dst_rise;
   logic [NF-1:0] fun_long_v;
   logic [NF-1:0] fun_short_v;

   for (genvar i = 0; i < ND; i++) begin : g_dst
      assign dst_live[i] = dst_req[i] & dst_en[i];
      assign dst_rise[i] = dst_live[i] & ~dst_prev_q[i];
   end

   for (genvar j = 0; j < NF; j++) begin : g_fun
      assign fun_long_v[j]  = fun_req[j] & fun_en[j] & ~fun_short[j];
      assign fun_short_v[j] = fun_req[j] & fun_en[j] &  fun_short[j];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dst_prev_q <= '0;
      else        dst_prev_q <= dst_live;
   end

   assign hard_act  = por_req | (|dst_live);
   assign dst_new   = |dst_rise;
   assign long_act  = (ext_req & ~ext_mask) | (|fun_long_v);
   assign short_act = |fun_short_v;

endmodule

// File: rtl/rst_esc_ctr.sv
`timescale 1ns/1ps
// Saturating destructive-event counter with threshold compare.
module rst_esc_ctr #(
   parameter int unsigned EW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          inc,
   input  logic [EW-1:0] thresh,
   output logic          lock
);

   localparam logic [EW-1:0] CNT_MAX = '1;

   logic [EW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        cnt_q <= '0;
      else if (clr)                      cnt_q <= '0;
      else if (inc && cnt_q != CNT_MAX)  cnt_q <= cnt_q + 1'b1;
   end

   assign lock = (thresh != '0) && (cnt_q >= thresh);

endmodule

// File: rtl/rst_phase_timer.sv
`timescale 1ns/1ps
// Per-phase elapsed-cycle counter, restarted on entry or on a new event.
module rst_phase_timer #(
   parameter int unsigned CW = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   output logic [CW-1:0] cnt
);

   localparam logic [CW-1:0] T_MAX = '1;

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (clr)            cnt_q <= '0;
      else if (cnt_q != T_MAX) cnt_q <= cnt_q + 1'b1;
   end

   assign cnt = cnt_q;

endmodule

// File: rtl/rst_phase_seq.sv
`timescale 1ns/1ps
module rst_phase_seq
   import rst_phase_pkg::*;
#(
   parameter int unsigned ND     = 2,
   parameter int unsigned NF     = 2,
   parameter int unsigned EW     = 3,
   parameter int unsigned MIN_P0 = 8,
   parameter int unsigned MIN_P1 = 750,
   parameter int unsigned MIN_P2 = 8,
   parameter int unsigned MIN_P3 = 160
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          por_req,
   input  logic [ND-1:0] dst_req,
   input  logic [ND-1:0] dst_en,
   input  logic          ext_req,
   input  logic          ext_mask,
   input  logic [NF-1:0] fun_req,
   input  logic [NF-1:0] fun_en,
   input  logic [NF-1:0] fun_short,
   input  logic          pwr_ok,
   input  logic          flash_done,
   input  logic          trim_done,
   input  logic          err_pin,
   input  logic          por_pin,
   input  logic          selftest_pend,
   input  logic          err_ovr,
   input  logic [EW-1:0] esc_thresh,
   output logic [4:0]    phase_oh,
   output logic          sys_rst,
   output logic          esc_lock
);

   localparam int unsigned MAX_A  = (MIN_P0 > MIN_P1) ? MIN_P0 : MIN_P1;
   localparam int unsigned MAX_B  = (MIN_P2 > MIN_P3) ? MIN_P2 : MIN_P3;
   localparam int unsigned MAX_M  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
   localparam int unsigned CW     = $clog2(MAX_M + 1);
   localparam logic [CW-1:0] LIM0 = CW'(MIN_P0 - 1);
   localparam logic [CW-1:0] LIM1 = CW'(MIN_P1 - 1);
   localparam logic [CW-1:0] LIM2 = CW'(MIN_P2 - 1);
   localparam logic [CW-1:0] LIM3 = CW'(MIN_P3 - 1);

   initial begin : g_param_chk
      assert (ND >= 1 && NF >= 1) else $error("rst_phase_seq: need at least one source per class");
      assert (EW >= 1 && EW <= 16) else $error("rst_phase_seq: EW out of range");
      assert (MIN_P0 >= 1 && MIN_P1 >= 1 && MIN_P2 >= 1 && MIN_P3 >= 1)
         else $error("rst_phase_seq: minimum phase lengths must be non-zero");
      assert (N_PHASE == 5) else $error("rst_phase_seq: phase count mismatch");
   end

   logic          hard_act;
   logic          dst_new;
   logic          long_act;
   logic          short_act;
   logic          lock_w;
   logic          tmr_clr;
   logic [CW-1:0] tmr_cnt;
   logic          err_ok;
   logic          pin_ok;
   logic          hold_evt;
   phase_e        cur_q;
   phase_e        nxt;
   logic [4:0]    oh_q;
   logic          sys_rst_q;

   rst_evt_class #(.ND(ND), .NF(NF)) u_class (
      .clk       (clk),
      .rst_n     (rst_n),
      .por_req   (por_req),
      .dst_req   (dst_req),
      .dst_en    (dst_en),
      .ext_req   (ext_req),
      .ext_mask  (ext_mask),
      .fun_req   (fun_req),
      .fun_en    (fun_en),
      .fun_short (fun_short),
      .hard_act  (hard_act),
      .dst_new   (dst_new),
      .long_act  (long_act),
      .short_act (short_act)
   );

   rst_esc_ctr #(.EW(EW)) u_esc (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (por_req),
      .inc    (dst_new),
      .thresh (esc_thresh),
      .lock   (lock_w)
   );

   rst_phase_timer #(.CW(CW)) u_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (tmr_clr),
      .cnt   (tmr_cnt)
   );

   assign err_ok = ~err_pin | selftest_pend | err_ovr;
   assign pin_ok = ~por_pin | selftest_pend;

   always_comb begin
      nxt      = cur_q;
      hold_evt = 1'b0;
      if (hard_act) begin
         nxt      = PH0;
         hold_evt = 1'b1;
      end else if (long_act && (cur_q == PH2 || cur_q == PH3 || cur_q == PH_IDLE)) begin
         nxt = PH1;
      end else if (short_act && cur_q == PH_IDLE) begin
         nxt = PH3;
      end else begin
         unique case (cur_q)
            PH0: if (pwr_ok && !lock_w && tmr_cnt >= LIM0) nxt = PH1;
            PH1: begin
               if (long_act)               hold_evt = 1'b1;
               else if (tmr_cnt >= LIM1)   nxt = PH2;
            end
            PH2: if (flash_done && tmr_cnt >= LIM2) nxt = PH3;
            PH3: begin
               if (short_act)              hold_evt = 1'b1;
               else if (trim_done && err_ok && pin_ok && tmr_cnt >= LIM3) nxt = PH_IDLE;
            end
            PH_IDLE: nxt = PH_IDLE;
            default: nxt = PH0;
         endcase
      end
   end

   assign tmr_clr = hold_evt | (nxt != cur_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q     <= PH0;
         oh_q      <= 5'b00001;
         sys_rst_q <= 1'b1;
      end else begin
         cur_q     <= nxt;
         oh_q      <= phase_to_oh(nxt);
         sys_rst_q <= (nxt != PH_IDLE);
      end
   end

   assign phase_oh = oh_q;
   assign sys_rst  = sys_rst_q;
   assign esc_lock = lock_w;

endmodule

// File: rtl/rst_phase_seq_chk.sv
`timescale 1ns/1ps
module rst_phase_seq_chk #(
   parameter int unsigned ND = 2,
   parameter int unsigned NF = 2,
   parameter int unsigned EW = 3
) (
   input logic          clk,
   input logic          rst_n,
   input logic          por_req,
   input logic [ND-1:0] dst_req,
   input logic [ND-1:0] dst_en,
   input logic          ext_req,
   input logic          ext_mask,
   input logic [NF-1:0] fun_req,
   input logic [NF-1:0] fun_en,
   input logic [NF-1:0] fun_short,
   input logic          pwr_ok,
   input logic          flash_done,
   input logic          trim_done,
   input logic          err_pin,
   input logic          por_pin,
   input logic          selftest_pend,
   input logic          err_ovr,
   input logic [EW-1:0] esc_thresh,
   input logic [4:0]    phase_oh,
   input logic          sys_rst,
   input logic          esc_lock
);

   logic c_hard, c_long, c_short;
   assign c_hard  = por_req | (|(dst_req & dst_en));
   assign c_long  = (ext_req & ~ext_mask) | (|(fun_req & fun_en & ~fun_short));
   assign c_short = |(fun_req & fun_en & fun_short);

   p_onehot_r13: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(phase_oh) == 1);
   p_sysrst_r13: assert property (@(posedge clk) disable iff (!rst_n)
      sys_rst == !phase_oh[4]);
   p_hard_jump_r2: assert property (@(posedge clk) disable iff (!rst_n)
      c_hard |=> phase_oh[0]);
   p_p0_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_oh[0] && !pwr_ok) |=> phase_oh[0]);
   p_long_jump_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!c_hard && c_long && (phase_oh[2] || phase_oh[3] || phase_oh[4])) |=> phase_oh[1]);
   p_p1_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_oh[1] && c_long) |=> !phase_oh[2]);
   p_p2_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_oh[2] && !flash_done) |=> !phase_oh[3]);
   p_short_jump_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_oh[4] && c_short && !c_hard && !c_long) |=> phase_oh[3]);
   p_p3_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_oh[3] && !trim_done) |=> !phase_oh[4]);
   p_idle_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(phase_oh[4]) |-> $past(phase_oh[3]));
   p_err_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_oh[3] && err_pin && !selftest_pend && !err_ovr) |=> !phase_oh[4]);
   p_pin_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_oh[3] && por_pin && !selftest_pend) |=> !phase_oh[4]);
   p_lock_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_oh[0] && esc_lock) |=> phase_oh[0]);
   p_zero_thr_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (esc_thresh == '0) |-> !esc_lock);

endmodule

bind rst_phase_seq rst_phase_seq_chk #(.ND(ND), .NF(NF), .EW(EW)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .por_req       (por_req),
   .dst_req       (dst_req),
   .dst_en        (dst_en),
   .ext_req       (ext_req),
   .ext_mask      (ext_mask),
   .fun_req       (fun_req),
   .fun_en        (fun_en),
   .fun_short     (fun_short),
   .pwr_ok        (pwr_ok),
   .flash_done    (flash_done),
   .trim_done     (trim_done),
   .err_pin       (err_pin),
   .por_pin       (por_pin),
   .selftest_pend (selftest_pend),
   .err_ovr       (err_ovr),
   .esc_thresh    (esc_thresh),
   .phase_oh      (phase_oh),
   .sys_rst       (sys_rst),
   .esc_lock      (esc_lock)
);

// File: tb/rst_phase_seq_tb_top.sv
`timescale 1ns/1ps
module rst_phase_seq_tb_top;

   localparam int ND = 2;
   localparam int NF = 2;
   localparam int EW = 3;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          por_req;
   logic [ND-1:0] dst_req, dst_en;
   logic          ext_req, ext_mask;
   logic [NF-1:0] fun_req, fun_en, fun_short;
   logic          pwr_ok, flash_done, trim_done;
   logic          err_pin, por_pin, selftest_pend, err_ovr;
   logic [EW-1:0] esc_thresh;
   logic [4:0]    phase_oh;
   logic          sys_rst, esc_lock;

   int n_chk  = 0;
   int n_fail = 0;
   int cyc    = 0;
   bit done   = 0;

   always #10 clk = ~clk;

   rst_phase_seq #(.ND(ND), .NF(NF), .EW(EW)) dut_i (
      .clk(clk), .rst_n(rst_n), .por_req(por_req), .dst_req(dst_req), .dst_en(dst_en),
      .ext_req(ext_req), .ext_mask(ext_mask), .fun_req(fun_req), .fun_en(fun_en),
      .fun_short(fun_short), .pwr_ok(pwr_ok), .flash_done(flash_done),
      .trim_done(trim_done), .err_pin(err_pin), .por_pin(por_pin),
      .selftest_pend(selftest_pend), .err_ovr(err_ovr), .esc_thresh(esc_thresh),
      .phase_oh(phase_oh), .sys_rst(sys_rst), .esc_lock(esc_lock)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // Reference model: phases 0..3, 4 = idle
   int     m_ph  = 0;
   int     m_cnt = 0;
   int     m_esc = 0;
   logic [ND-1:0] m_dq = '0;
   localparam int MINS [4] = '{8, 750, 8, 160};

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_ph = 0; m_cnt = 0; m_esc = 0; m_dq = '0;
      end else begin
         bit hard, lng, sht, newd, lck, rst_t;
         int nph;
         hard  = por_req || ((dst_req & dst_en) != 0);
         lng   = (ext_req && !ext_mask) || ((fun_req & fun_en & ~fun_short) != 0);
         sht   = (fun_req & fun_en & fun_short) != 0;
         newd  = (dst_req & dst_en & ~m_dq) != 0;
         lck   = (esc_thresh != 0) && (m_esc >= esc_thresh);
         nph   = m_ph;
         rst_t = 0;
         if (hard) begin nph = 0; rst_t = 1; end
         else if (lng && m_ph >= 2) nph = 1;
         else if (sht && m_ph == 4) nph = 3;
         else if (m_ph == 0) begin
            if (pwr_ok && !lck && m_cnt + 1 >= MINS[0]) nph = 1;
         end else if (m_ph == 1) begin
            if (lng) rst_t = 1;
            else if (m_cnt + 1 >= MINS[1]) nph = 2;
         end else if (m_ph == 2) begin
            if (flash_done && m_cnt + 1 >= MINS[2]) nph = 3;
         end else if (m_ph == 3) begin
            if (sht) rst_t = 1;
            else if (trim_done && (!err_pin || selftest_pend || err_ovr) &&
                     (!por_pin || selftest_pend) && m_cnt + 1 >= MINS[3]) nph = 4;
         end
         if (rst_t || nph != m_ph) m_cnt = 0;
         else if (m_cnt < 1023) m_cnt++;
         if (por_req) m_esc = 0;
         else if (newd && m_esc < 7) m_esc++;
         m_dq = dst_req & dst_en;
         m_ph = nph;
      end
   end

   // Per-cycle comparison, away from the active edge (R13, R11, R12 via model)
   always @(negedge clk) begin
      if (rst_n && !done) begin
         bit exp_lock;
         exp_lock = (esc_thresh != 0) && (m_esc >= esc_thresh);
         chk(phase_oh == (5'b1 << m_ph), "R13 model phase", phase_oh, 1 << m_ph);
         chk(sys_rst == (m_ph != 4), "R13 model sys_rst", sys_rst, m_ph != 4);
         chk(esc_lock == exp_lock, "R11 model esc_lock", esc_lock, exp_lock);
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         done = 1;
         chk(0, "watchdog", cyc, 150000);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic expect_ph(input int ph, input string tag);
      chk(phase_oh == (5'b1 << ph), tag, phase_oh, 1 << ph);
   endtask

   task automatic run_to_idle();
      for (int i = 0; i < 2000 && !phase_oh[4]; i++) tick(1);
      expect_ph(4, "R13 reach idle");
   endtask

   task automatic short_pulse();
      fun_req = 2'b01; tick(1); fun_req = 2'b00;
   endtask

   initial begin
      rst_n = 0; por_req = 0; dst_req = '0; dst_en = 2'b01;
      ext_req = 0; ext_mask = 0; fun_req = '0; fun_en = 2'b11; fun_short = 2'b01;
      pwr_ok = 0; flash_done = 0; trim_done = 0;
      err_pin = 0; por_pin = 0; selftest_pend = 0; err_ovr = 0; esc_thresh = '0;
      tick(3);
      expect_ph(0, "R1 reset phase");
      chk(sys_rst == 1, "R1 reset sys_rst", sys_rst, 1);
      chk(esc_lock == 0, "R1 reset esc_lock", esc_lock, 0);
      rst_n = 1;
      tick(20);  expect_ph(0, "R3 wait pwr_ok");
      pwr_ok = 1;
      tick(1);   expect_ph(1, "R3 exit phase0");
      tick(749); expect_ph(1, "R5 still phase1");
      tick(1);   expect_ph(2, "R5 exit phase1");
      tick(20);  expect_ph(2, "R6 wait flash");
      flash_done = 1;
      tick(1);   expect_ph(3, "R6 exit phase2");
      tick(170); expect_ph(3, "R8 wait trim");
      trim_done = 1;
      tick(1);   expect_ph(4, "R8 enter idle");
      chk(sys_rst == 0, "R13 idle release", sys_rst, 0);

      // short entry with held request restarting timer
      fun_req = 2'b01; tick(1); expect_ph(3, "R7 short to phase3");
      tick(5); fun_req = 2'b00;
      tick(159); expect_ph(3, "R8 160 after short");
      tick(1);   expect_ph(4, "R8 idle after short");

      // error pin gate
      err_pin = 1; short_pulse();
      tick(170); expect_ph(3, "R9 err_pin blocks");
      selftest_pend = 1; tick(1); expect_ph(4, "R9 selftest lifts");
      selftest_pend = 0; short_pulse();
      tick(170); expect_ph(3, "R9 err_pin blocks again");
      err_ovr = 1; tick(1); expect_ph(4, "R9 override lifts");
      err_pin = 0;

      // por pin gate, override does not help
      por_pin = 1; short_pulse();
      tick(170); expect_ph(3, "R10 por_pin blocks");
      selftest_pend = 1; tick(1); expect_ph(4, "R10 selftest lifts");
      selftest_pend = 0; por_pin = 0; err_ovr = 0;

      // masked and unmasked external request
      ext_mask = 1; ext_req = 1; tick(3); expect_ph(4, "R4 masked ignored");
      ext_mask = 0; tick(1); expect_ph(1, "R4 external to phase1");
      ext_req = 0; fun_req = 2'b01; tick(1); expect_ph(1, "R7 short ignored in phase1");
      fun_req = 2'b00;
      tick(748); expect_ph(1, "R5 phase1 window");
      tick(1);   expect_ph(2, "R5 phase1 done");
      run_to_idle();

      // disabled destructive source
      dst_req = 2'b10; tick(3); expect_ph(4, "R2 disabled source ignored");
      dst_req = 2'b00;

      // escalation
      esc_thresh = 3'd2;
      dst_req = 2'b01; tick(1); expect_ph(0, "R2 destructive to phase0");
      dst_req = 2'b00; tick(10); expect_ph(1, "R11 below threshold exits");
      chk(esc_lock == 0, "R11 no lock at 1", esc_lock, 0);
      dst_req = 2'b01; tick(1); dst_req = 2'b00;
      tick(20); expect_ph(0, "R11 locked in phase0");
      chk(esc_lock == 1, "R11 lock at threshold", esc_lock, 1);
      por_req = 1; tick(1); por_req = 0;
      chk(esc_lock == 0, "R11 por clears count", esc_lock, 0);
      tick(8); expect_ph(1, "R11 exit after clear");
      esc_thresh = 3'd0;
      for (int k = 0; k < 3; k++) begin
         dst_req = 2'b01; tick(1); dst_req = 2'b00; tick(1);
      end
      chk(esc_lock == 0, "R11 zero threshold", esc_lock, 0);
      run_to_idle();

      // priority
      dst_req = 2'b01; ext_req = 1; fun_req = 2'b01; tick(1);
      expect_ph(0, "R12 hard wins");
      dst_req = 2'b00; tick(10); expect_ph(1, "R12 long held in phase1");
      ext_req = 0; fun_req = 2'b00;
      run_to_idle();
      ext_req = 1; fun_req = 2'b01; tick(1);
      expect_ph(1, "R12 long over short");
      ext_req = 0; fun_req = 2'b00;
      run_to_idle();

      // hard request from phase3
      short_pulse(); expect_ph(3, "R7 short again");
      por_req = 1; tick(1); expect_ph(0, "R2 por from phase3");
      por_req = 0;
      run_to_idle();

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule